// File: doc/BRIEF.md
# Six-State Hardwired Instruction Sequencer

This block is the control unit of a small accumulator machine whose program counter, memory address register, RAM, instruction register, accumulator, B register, adder-subtractor and output register all share one 8-bit bus. A one-hot ring of six timing states advances on every rising clock edge, and each instruction takes exactly one full trip around the ring. The first three states fetch the instruction byte. The upper nibble of that byte holds the opcode, and the lower nibble holds a memory address. The block receives the opcode nibble from the instruction register, decodes it, and drives a bundle of enable and load strobes for the last three states.

The control word is held in a register that is clocked on the falling edge. Each strobe is therefore settled half a cycle before the datapath samples it on the next rising edge. A halt opcode freezes the ring and forces every strobe to its inactive level. Only the active-low clear releases it. Clear is asynchronous and returns the ring to the first fetch state.

Top module: `seq_ctrl_top`

## Requirements
- R1: After reset, every instruction other than halt occupies exactly six consecutive control states, T1 to T6. The state after T6 is T1 of the next instruction.
- R2: The fetch states behave the same for any opcode input value. In T1, `pc_en`=1 and `mar_ld_n`=0. In T2, `pc_cnt`=1. In T3, `ram_rd_n`=0 and `ir_ld_n`=0.
- R3: For load-accumulator (opcode 0x0), T4 drives `ir_en_n`=0 and `mar_ld_n`=0. T5 drives `ram_rd_n`=0 and `acc_ld_n`=0. T6 is idle.
- R4: For add (opcode 0x1), T4 is the same as for load. T5 drives `ram_rd_n`=0 and `b_ld_n`=0. T6 drives `alu_en`=1 and `acc_ld_n`=0. `alu_sub` stays 0 throughout.
- R5: Subtract (opcode 0x2) has the same strobes as add, and in addition drives `alu_sub`=1 in T4, T5 and T6.
- R6: For output (opcode 0xE), T4 drives `acc_en`=1 and `out_ld_n`=0. T5 and T6 are idle.
- R7: Once a halt (opcode 0xF) reaches T4, every strobe stays idle from T4 onward, whatever the opcode input does, until clear is asserted.
- R8: Any opcode other than 0x0, 0x1, 0x2, 0xE and 0xF leaves T4 to T6 idle, and the next fetch follows.
- R9: While `clr_n`=0, all strobes are idle immediately, with no clock edge needed. The first control word after release is the T1 word.
- R10: The strobes change only on falling clock edges. Just after a rising edge they still show the previous state's word.
- R11: In every state, at most one bus source is active. The bus sources are `pc_en`, `ram_rd_n`=0, `ir_en_n`=0, `acc_en` and `alu_en`.
- Idle level of every strobe: `pc_cnt`, `pc_en`, `acc_en`, `alu_en` and `alu_sub` are 0. All `_n` strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ring advances on rising edges and the strobes update on falling edges |
| clr_n | input | 1 | Asynchronous clear, active low |
| opcode | input | 4 | Opcode nibble from the instruction register |
| pc_cnt | output | 1 | Program counter increment, active high |
| pc_en | output | 1 | Program counter drives the bus, active high |
| mar_ld_n | output | 1 | Memory address register load, active low |
| ram_rd_n | output | 1 | RAM drives the bus, active low |
| ir_ld_n | output | 1 | Instruction register load, active low |
| ir_en_n | output | 1 | Instruction register address nibble drives the bus, active low |
| acc_ld_n | output | 1 | Accumulator load, active low |
| acc_en | output | 1 | Accumulator drives the bus, active high |
| b_ld_n | output | 1 | B register load, active low |
| alu_sub | output | 1 | Adder-subtractor subtract select, active high |
| alu_en | output | 1 | Adder-subtractor result drives the bus, active high |
| out_ld_n | output | 1 | Output register load, active low |

## Verification
The bench runs load, add, subtract and output instructions back to back. It presents a different unrelated opcode value during each fetch. This shows that the fetch states ignore the opcode, and that add and subtract differ only in the subtract select. An undefined opcode must give idle execute states, and a halt must stay silent while the opcode input keeps changing. A clear asserted partway through an instruction must reset the sequence to T1 at once. Each state is sampled both just after the rising edge and just after the falling edge, so a word that moves on the wrong edge is caught.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
  localparam int OP_W = 4;
  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_LDA = 4'h0;
  localparam op_t OP_ADD = 4'h1;
  localparam op_t OP_SUB = 4'h2;
  localparam op_t OP_OUT = 4'hE;
  localparam op_t OP_HLT = 4'hF;

  // zero-based ring positions
  localparam int ST_T1 = 0;
  localparam int ST_T2 = 1;
  localparam int ST_T3 = 2;
  localparam int ST_T4 = 3;
  localparam int ST_T5 = 4;
  localparam int ST_T6 = 5;

  // internal control word, every field active high
  typedef struct packed {
    logic pc_cnt;
    logic pc_en;
    logic mar_ld;
    logic ram_rd;
    logic ir_ld;
    logic ir_en;
    logic acc_ld;
    logic acc_en;
    logic b_ld;
    logic alu_sub;
    logic alu_en;
    logic out_ld;
  } ctrl_t;

  function automatic logic uses_mem(input op_t op);
    return (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic is_arith(input op_t op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic ctrl_t ctrl_for(input int st, input op_t op);
    ctrl_t c;
    c = '0;
    case (st)
      ST_T1: begin c.pc_en = 1'b1; c.mar_ld = 1'b1; end
      ST_T2: c.pc_cnt = 1'b1;
      ST_T3: begin c.ram_rd = 1'b1; c.ir_ld = 1'b1; end
      ST_T4: begin
        if (uses_mem(op)) begin c.ir_en = 1'b1; c.mar_ld = 1'b1; end
        if (op == OP_OUT) begin c.acc_en = 1'b1; c.out_ld = 1'b1; end
      end
      ST_T5: begin
        if (op == OP_LDA) begin c.ram_rd = 1'b1; c.acc_ld = 1'b1; end
        if (is_arith(op)) begin c.ram_rd = 1'b1; c.b_ld = 1'b1; end
      end
      ST_T6: begin
        if (is_arith(op)) begin c.alu_en = 1'b1; c.acc_ld = 1'b1; end
      end
      default: c = '0;
    endcase
    if ((st >= ST_T4) && (st <= ST_T6) && (op == OP_SUB)) c.alu_sub = 1'b1;
    return c;
  endfunction

  function automatic int bus_sources(input ctrl_t w);
    return int'(w.pc_en) + int'(w.ram_rd) + int'(w.ir_en) + int'(w.acc_en) + int'(w.alu_en);
  endfunction

  function automatic logic any_load(input ctrl_t w);
    return w.mar_ld | w.ir_ld | w.acc_ld | w.b_ld | w.out_ld;
  endfunction
endpackage

// File: rtl/seq_ring.sv
module seq_ring
  import seq_ctrl_pkg::*;
#(
  parameter int NUM_STATES = 6
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  op_t                   opcode,
  output logic [NUM_STATES-1:0] ring,
  output logic                  halted,
  output logic                  halt_hit
);
  localparam logic [NUM_STATES-1:0] RING_START = {{(NUM_STATES-1){1'b0}}, 1'b1};

  logic [NUM_STATES-1:0] ring_next;

  assign halt_hit  = ring[ST_T4] && (opcode == OP_HLT);
  assign ring_next = {ring[NUM_STATES-2:0], ring[NUM_STATES-1]};

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      ring   <= RING_START;
      halted <= 1'b0;
    end else if (!halted) begin
      if (halt_hit) halted <= 1'b1;
      else          ring   <= ring_next;
    end
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!clr_n)
    $countones(ring) == 1); // R1
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
    (!halted && ring[NUM_STATES-1]) |=> ring[0]); // R1
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    halted |=> (halted && $stable(ring))); // R7
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_ctrl_pkg::*;
#(
  parameter int NUM_STATES = 6
) (
  input  logic [NUM_STATES-1:0] ring,
  input  logic                  halted,
  input  op_t                   opcode,
  output ctrl_t                 word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (ring[i]) word = word | ctrl_for(i, opcode);
    end
    if (halted) word = '0;
  end

  always_comb begin
    AST_DECODE_ONE_SOURCE: assert (bus_sources(word) <= 1); // R11
  end
endmodule

// File: rtl/seq_word_reg.sv
module seq_word_reg
  import seq_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  clr_n,
  input  ctrl_t word_d,
  output ctrl_t word_q
);
  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/seq_ctrl_top.sv
module seq_ctrl_top
  import seq_ctrl_pkg::*;
#(
  parameter int NUM_STATES = 6
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic [3:0] opcode,
  output logic       pc_cnt,
  output logic       pc_en,
  output logic       mar_ld_n,
  output logic       ram_rd_n,
  output logic       ir_ld_n,
  output logic       ir_en_n,
  output logic       acc_ld_n,
  output logic       acc_en,
  output logic       b_ld_n,
  output logic       alu_sub,
  output logic       alu_en,
  output logic       out_ld_n
);
  logic [NUM_STATES-1:0] ring;
  logic                  halted;
  logic                  halt_hit;
  ctrl_t                 word_d;
  ctrl_t                 word_q;

  seq_ring #(.NUM_STATES(NUM_STATES)) ring_i (
    .clk(clk), .clr_n(clr_n), .opcode(opcode),
    .ring(ring), .halted(halted), .halt_hit(halt_hit)
  );

  seq_decode #(.NUM_STATES(NUM_STATES)) decode_i (
    .ring(ring), .halted(halted), .opcode(opcode), .word(word_d)
  );

  seq_word_reg word_i (
    .clk(clk), .clr_n(clr_n), .word_d(word_d), .word_q(word_q)
  );

  assign pc_cnt   =  word_q.pc_cnt;
  assign pc_en    =  word_q.pc_en;
  assign mar_ld_n = ~word_q.mar_ld;
  assign ram_rd_n = ~word_q.ram_rd;
  assign ir_ld_n  = ~word_q.ir_ld;
  assign ir_en_n  = ~word_q.ir_en;
  assign acc_ld_n = ~word_q.acc_ld;
  assign acc_en   =  word_q.acc_en;
  assign b_ld_n   = ~word_q.b_ld;
  assign alu_sub  =  word_q.alu_sub;
  assign alu_en   =  word_q.alu_en;
  assign out_ld_n = ~word_q.out_ld;

  logic [4:0] src_vec;
  logic       load_any;
  assign src_vec  = {pc_en, ~ram_rd_n, ~ir_en_n, acc_en, alu_en};
  assign load_any = ~mar_ld_n | ~ir_ld_n | ~acc_ld_n | ~b_ld_n | ~out_ld_n;

  AST_ONE_BUS_SOURCE: assert property (@(posedge clk) disable iff (!clr_n)
    $countones(src_vec) <= 1); // R11
  AST_LOAD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!clr_n)
    load_any |-> ($countones(src_vec) == 1)); // R11
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!clr_n)
    halted |-> (!pc_cnt && !pc_en && !acc_en && !alu_en && !alu_sub &&
                mar_ld_n && ram_rd_n && ir_ld_n && ir_en_n && acc_ld_n && b_ld_n && out_ld_n)); // R7
  AST_ALU_FEEDS_ACC: assert property (@(posedge clk) disable iff (!clr_n)
    alu_en |-> !acc_ld_n); // R4
endmodule

// File: tb/seq_ctrl_top_tb_top.sv
`timescale 1ns/100ps
module seq_ctrl_top_tb_top;
  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic pc_cnt, pc_en, mar_ld_n, ram_rd_n, ir_ld_n, ir_en_n;
  logic acc_ld_n, acc_en, b_ld_n, alu_sub, alu_en, out_ld_n;

  always #2 clk = ~clk;

  seq_ctrl_top dut_i (
    .clk(clk), .clr_n(clr_n), .opcode(opcode),
    .pc_cnt(pc_cnt), .pc_en(pc_en), .mar_ld_n(mar_ld_n), .ram_rd_n(ram_rd_n),
    .ir_ld_n(ir_ld_n), .ir_en_n(ir_en_n), .acc_ld_n(acc_ld_n), .acc_en(acc_en),
    .b_ld_n(b_ld_n), .alu_sub(alu_sub), .alu_en(alu_en), .out_ld_n(out_ld_n)
  );

  int checks = 0;
  int fails  = 0;
  int st     = 1;
  bit mh     = 1'b0;
  logic [11:0] last_exp;

  localparam logic [11:0] LOW_MASK = 12'h3E9;
  localparam logic [11:0] IDLE     = 12'h3E9;

  function automatic logic [11:0] outs();
    return {pc_cnt, pc_en, mar_ld_n, ram_rd_n, ir_ld_n, ir_en_n,
            acc_ld_n, acc_en, b_ld_n, alu_sub, alu_en, out_ld_n};
  endfunction

  // bit order: 11 pc_cnt,10 pc_en,9 mar,8 ram,7 ir_ld,6 ir_en,5 acc_ld,4 acc_en,3 b,2 sub,1 alu,0 out
  function automatic logic [11:0] expect_word(int s, logic [3:0] op);
    logic [11:0] h = '0;
    bit mem = (op == 4'h0) || (op == 4'h1) || (op == 4'h2);
    bit ar  = (op == 4'h1) || (op == 4'h2);
    if (s == 1) h = 12'b0110_0000_0000;
    if (s == 2) h = 12'b1000_0000_0000;
    if (s == 3) h = 12'b0001_1000_0000;
    if (s == 4 && mem) h = 12'b0010_0100_0000;
    if (s == 4 && op == 4'hE) h = 12'b0000_0001_0001;
    if (s == 5 && op == 4'h0) h = 12'b0001_0010_0000;
    if (s == 5 && ar) h = 12'b0001_0000_1000;
    if (s == 6 && ar) h = 12'b0000_0010_0010;
    if (s >= 4 && op == 4'h2) h[2] = 1'b1;
    return h ^ LOW_MASK;
  endfunction

  function automatic string tag_for(int s, logic [3:0] op, bit halted_m);
    if (halted_m) return "R7";
    if (s == 1) return "R1";
    if (s <= 3) return "R2";
    case (op)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h2: return "R5";
      4'hE: return "R6";
      4'hF: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_bus();
    logic [11:0] o = outs();
    int n = int'(o[10]) + int'(!o[8]) + int'(!o[6]) + int'(o[4]) + int'(o[1]);
    checks++;
    if (n > 1) begin
      fails++;
      $display("FAIL R11 t=%0t actual=%0d sources expected=<=1", $time, n);
    end
  endtask

  // one rising edge; op_next is presented for the new state
  task automatic tick(logic [3:0] op_next);
    logic [3:0] op_prev = opcode;
    @(posedge clk);
    #1;
    check("R10", outs(), last_exp);
    if (!mh) begin
      if (st == 4 && op_prev == 4'hF) mh = 1'b1;
      else st = (st % 6) + 1;
    end
    opcode = op_next;
    #2;
    last_exp = mh ? IDLE : expect_word(st, opcode);
    check(tag_for(st, opcode, mh), outs(), last_exp);
    check_bus();
  endtask

  task automatic do_clear(logic [3:0] op_first);
    clr_n = 1'b0;
    #0.5;
    check("R9", outs(), IDLE);
    @(posedge clk);
    #1;
    check("R9", outs(), IDLE);
    st = 1;
    mh = 1'b0;
    opcode = op_first;
    clr_n = 1'b1;
    #2;
    last_exp = expect_word(1, opcode);
    check("R9", outs(), last_exp);
  endtask

  // starts with T1 showing; ends with T1 of the next instruction showing
  task automatic run_instr(logic [3:0] op, logic [3:0] g2, logic [3:0] g3, logic [3:0] gnext);
    tick(g2);
    tick(g3);
    tick(op);
    tick(op);
    tick(op);
    tick(gnext);
  endtask

  task automatic t_load();     run_instr(4'h0, 4'h7, 4'hF, 4'hE); endtask
  task automatic t_add();      run_instr(4'h1, 4'h2, 4'hE, 4'h3); endtask
  task automatic t_sub();      run_instr(4'h2, 4'h1, 4'h0, 4'hF); endtask
  task automatic t_output();   run_instr(4'hE, 4'hF, 4'h2, 4'h9); endtask
  task automatic t_undefined();
    run_instr(4'h5, 4'h0, 4'h1, 4'h6);
    run_instr(4'hB, 4'hE, 4'h2, 4'hA);
  endtask

  task automatic t_halt();
    tick(4'h3);
    tick(4'h0);
    tick(4'hF);
    for (int i = 0; i < 10; i++) tick(4'(i));
    // the model must have stayed halted
    checks++;
    if (!mh) begin fails++; $display("FAIL R7 model not halted actual=0 expected=1"); end
  endtask

  task automatic t_clear_mid();
    tick(4'h4);
    tick(4'h8);
    tick(4'h1);
    tick(4'h1);
    do_clear(4'hC);
  endtask

  bit done = 1'b0;

  initial begin
    do_clear(4'hA);
    t_load();
    t_add();
    t_sub();
    t_output();
    t_undefined();
    t_sub();
    t_halt();
    do_clear(4'h0);
    t_load();
    t_clear_mid();
    t_add();
    t_output();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule